// File: doc/BRIEF.md
# DMA External Request Handshake Controller

A single-channel controller that converts an external device's active-low DMA request into a sequence of transfer cycles on an abstract bus. For each transfer it produces the acknowledge strobe and the read and write phase strobes. For each request it accepts, it produces a one-cycle accept strobe. A four-bit mode word selects four things: burst or cycle-steal operation, falling-edge or low-level request detection, single or dual addressing, and, in dual addressing, whether the acknowledge marks the read phase or the write phase.

Software arms the channel with a one-cycle `start_i` pulse. The pulse loads the transfer count and latches the mode word. The channel then samples the request. An accepted request is followed by a fixed wait before the first transfer. Every completed transfer decrements the remaining count. When the count reaches zero the channel raises `done_o` and stays idle until it is armed again. With level detection, the device can hold a run back by releasing its request after it sees the accept strobe.

Top module: `dma_hs_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `accept_o`, `ack_o`, `rd_o`, `wr_o` and `done_o` are low and `remain_o` is zero.
- R2: The first strobe of the transfer that follows an accept (`ack_o` or `rd_o`) rises exactly LAT (5) cycles after `accept_o` rises. No transfer strobe is high in the accept cycle or in the cycle after it.
- R3: With mode_i[1]=0 (edge), the request is detected by a high-to-low transition of the registered request. With mode_i[0]=1 (burst), a single accept starts the run, all transfers follow back to back, and request activity after the accept has no effect.
- R4: With mode_i[0]=0 (cycle-steal), every transfer is preceded by its own accept and its own LAT-cycle wait.
- R5: With mode_i[2]=0 (single addressing), each transfer is one cycle with `ack_o` high, and `rd_o` and `wr_o` stay low.
- R6: With mode_i[2]=1 (dual addressing), each transfer is one `rd_o` cycle followed by one `wr_o` cycle. `ack_o` is high only in the read cycle when mode_i[3]=0, and only in the write cycle when mode_i[3]=1.
- R7: `remain_o` decrements by one at the end of each transfer. When it reaches zero, `done_o` goes high and the run ends after exactly `count_i` transfers.
- R8: With mode_i[1]=1 (level), releasing the request during the wait after an accept cancels that transfer. No further accept is issued while the request stays high, and `remain_o` is unchanged. Asserting the request again resumes the run.
- R9: With level detection in burst mode, a request held low gives one accept, followed by back-to-back transfers until the count is used up.
- R10: After `done_o` is set, the request is not accepted until `start_i` arms the channel again. Arming with `count_i` equal to zero sets `done_o` at once and produces no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_ni | input | 1 | External DMA request, active low |
| start_i | input | 1 | Arm pulse: loads count and mode when idle |
| mode_i | input | 4 | [0] burst, [1] level detect, [2] dual address, [3] acknowledge on write |
| count_i | input | CNT_W | Number of transfers to run |
| accept_o | output | 1 | One-cycle strobe when a request is accepted |
| ack_o | output | 1 | Acknowledge to the requesting device |
| rd_o | output | 1 | Read phase strobe (dual addressing) |
| wr_o | output | 1 | Write phase strobe (dual addressing) |
| remain_o | output | CNT_W | Transfers still to run |
| done_o | output | 1 | Count used up |

## Verification
Randomly chosen mode words and counts run complete transfers. The request is driven according to the mode: held low for level detection, pulsed once per transfer for edge cycle-steal, and pulsed once then toggled at random for an edge burst. The accept count separates burst from cycle-steal operation. The strobe span separates back-to-back bursts from spaced transfers, and the random toggling shows that an edge burst ignores the request once it has started. The phase strobes separate single from dual addressing and show which phase carries the acknowledge. Directed cases cover a level release during the wait, a zero count, and a request held after completion.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAMPLE,
    ST_WAIT,
    ST_PH1,
    ST_PH2
  } state_e;

  // packed from msb: bit0 = burst, bit1 = level, bit2 = dual, bit3 = ack on write
  typedef struct packed {
    logic ack_wr;
    logic dual;
    logic level;
    logic burst;
  } mode_t;

endpackage

// File: rtl/dma_hs_req.sv
module dma_hs_req #(
  parameter int unsigned STAGES = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  input  logic level_i,
  output logic active_o,
  output logic released_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              req_act;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= ~req_ni;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign req_act = sync_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= req_act;
  end

  // edge: fresh assertion only; level: asserted now
  assign active_o   = level_i ? req_act : (req_act & ~prev_q);
  assign released_o = ~req_act;

endmodule

// File: rtl/dma_hs_timer.sv
module dma_hs_timer #(
  parameter int unsigned LAT = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic zero_o
);

  localparam int unsigned W = $clog2(LAT + 1);
  localparam logic [W-1:0] RELOAD = W'(LAT - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (load_i)                    cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  AST_TMR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= RELOAD); // R2
  AST_TMR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !load_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R2

endmodule

// File: rtl/dma_hs_count.sv
module dma_hs_count #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic [CW-1:0] remain_o,
  output logic          last_o,
  output logic          done_o
);

  logic [CW-1:0] remain_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      done_q   <= 1'b0;
    end else if (load_i) begin
      remain_q <= load_val_i;
      done_q   <= (load_val_i == '0);
    end else if (dec_i) begin
      remain_q <= remain_q - 1'b1;
      if (remain_q == CW'(1)) done_q <= 1'b1;
    end
  end

  assign remain_o = remain_q;
  assign done_o   = done_q;
  assign last_o   = (remain_q == CW'(1));

  AST_DEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> remain_q == $past(remain_q) - 1'b1); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> remain_q != '0); // R7
  AST_DONE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> remain_q == '0); // R7

endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned LAT    = 5,
  parameter int unsigned STAGES = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_ni,
  input  logic             start_i,
  input  logic [3:0]       mode_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             accept_o,
  output logic             ack_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic [CNT_W-1:0] remain_o,
  output logic             done_o
);

  state_e state_q, state_d;
  mode_t  mode_q;

  logic req_active, req_released;
  logic tmr_zero, tmr_load;
  logic cnt_load, cnt_dec, cnt_last;
  logic acc_d, xfer_end;

  dma_hs_req #(.STAGES(STAGES)) i_req (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_ni     (req_ni),
    .level_i    (mode_q.level),
    .active_o   (req_active),
    .released_o (req_released)
  );

  dma_hs_timer #(.LAT(LAT)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .run_i  (state_q == ST_WAIT),
    .zero_o (tmr_zero)
  );

  dma_hs_count #(.CW(CNT_W)) i_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_load),
    .load_val_i (count_i),
    .dec_i      (cnt_dec),
    .remain_o   (remain_o),
    .last_o     (cnt_last),
    .done_o     (done_o)
  );

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    tmr_load = 1'b0;
    acc_d    = 1'b0;
    xfer_end = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        cnt_load = 1'b1;
        if (count_i != '0) state_d = ST_SAMPLE;
      end
      ST_SAMPLE: if (req_active) begin
        acc_d    = 1'b1;
        tmr_load = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        if (mode_q.level && req_released) state_d = ST_SAMPLE;  // device suspends
        else if (tmr_zero)                 state_d = ST_PH1;
      end
      ST_PH1: begin
        if (mode_q.dual) state_d = ST_PH2;
        else             xfer_end = 1'b1;
      end
      ST_PH2:  xfer_end = 1'b1;
      default: state_d = ST_IDLE;
    endcase
    if (xfer_end) begin
      if (cnt_last)
        state_d = ST_IDLE;
      else if (mode_q.burst && !(mode_q.level && req_released))
        state_d = ST_PH1;
      else
        state_d = ST_SAMPLE;
    end
  end

  assign cnt_dec = xfer_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      mode_q   <= '0;
      accept_o <= 1'b0;
      ack_o    <= 1'b0;
      rd_o     <= 1'b0;
      wr_o     <= 1'b0;
    end else begin
      state_q  <= state_d;
      if (state_q == ST_IDLE && start_i) mode_q <= mode_t'(mode_i);
      accept_o <= acc_d;
      rd_o     <= (state_d == ST_PH1) && mode_q.dual;
      wr_o     <= (state_d == ST_PH2);
      ack_o    <= ((state_d == ST_PH1) && !(mode_q.dual && mode_q.ack_wr)) ||
                  ((state_d == ST_PH2) && mode_q.ack_wr);
    end
  end

  AST_PHASE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o)); // R6
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> $past(rd_o)); // R6
  AST_DUAL_ACK_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q.dual && ack_o) |-> (mode_q.ack_wr ? wr_o : rd_o)); // R6
  AST_SINGLE_NO_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q.dual |-> (!rd_o && !wr_o)); // R5
  AST_ACCEPT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> !(ack_o || rd_o || wr_o)); // R2
  AST_ACCEPT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !(ack_o || rd_o || wr_o)); // R2
  AST_LEVEL_SUSPEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && mode_q.level && req_released) |=> !(ack_o || rd_o || wr_o)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !accept_o); // R10

endmodule

// File: tb/test_dma_hs_ctrl.sv
module test_dma_hs_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int LAT = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_n = 1'b1;
  logic             start = 1'b0;
  logic [3:0]       mode = '0;
  logic [CNT_W-1:0] count = '0;
  logic             accept, ack, rd, wr, done;
  logic [CNT_W-1:0] remain;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_acc = 0, n_ack = 0, n_rd = 0, n_wr = 0, n_phase_bad = 0;
  int first_acc = -1, first_str = -1, last_str = -1;
  logic prev_rd = 1'b0;
  logic [3:0] cur_mode = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_hs_ctrl #(.CNT_W(CNT_W), .LAT(LAT), .STAGES(1)) i_dma_hs_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_ni(req_n), .start_i(start),
    .mode_i(mode), .count_i(count), .accept_o(accept), .ack_o(ack),
    .rd_o(rd), .wr_o(wr), .remain_o(remain), .done_o(done)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (accept) begin
        n_acc++;
        if (first_acc < 0) first_acc = cyc;
      end
      if (ack || rd || wr) begin
        if (first_str < 0) first_str = cyc;
        last_str = cyc;
      end
      if (ack) n_ack++;
      if (rd)  n_rd++;
      if (wr)  n_wr++;
      if (cur_mode[2]) begin
        if (ack && !(cur_mode[3] ? wr : rd)) n_phase_bad++;
        if (wr && !prev_rd) n_phase_bad++;
      end else if (rd || wr) n_phase_bad++;
      prev_rd = rd;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_accepts(input logic [3:0] m, input int c);
    return m[0] ? 1 : c;
  endfunction
  function automatic int exp_phase(input logic [3:0] m, input int c);
    return m[2] ? c : 0;
  endfunction
  function automatic int exp_span(input logic [3:0] m, input int c);
    return (m[2] ? 2 : 1) * c - 1;
  endfunction

  task automatic clear_mon(input logic [3:0] m);
    cur_mode = m;
    n_acc = 0; n_ack = 0; n_rd = 0; n_wr = 0; n_phase_bad = 0;
    first_acc = -1; first_str = -1; last_str = -1;
  endtask

  task automatic arm(input logic [3:0] m, input int c);
    @(negedge clk);
    start = 1'b1; mode = m; count = CNT_W'(c);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_case(input logic [3:0] m, input int c);
    string acc_tag, ph_tag;
    req_n = 1'b1;
    repeat (3) @(negedge clk);
    clear_mon(m);
    arm(m, c);
    if (m[1]) begin
      req_n = 1'b0;
      wait_done();
    end else if (m[0]) begin
      req_n = 1'b0;
      repeat (2) @(negedge clk);
      req_n = 1'b1;
      while (n_acc == 0) @(negedge clk);
      while (!done) begin
        req_n = 1'($urandom);       // R3: ignored during the burst
        @(negedge clk);
      end
    end else begin
      for (int i = 0; i < c; i++) begin
        repeat (2) @(negedge clk);
        req_n = 1'b0;
        repeat (2) @(negedge clk);
        req_n = 1'b1;
        while (n_ack <= i) @(negedge clk);
      end
      wait_done();
    end
    @(negedge clk);
    req_n = 1'b1;
    acc_tag = m[0] ? (m[1] ? "R9 accepts" : "R3 accepts") : "R4 accepts";
    ph_tag  = m[2] ? "R6" : "R5";
    chk(acc_tag, n_acc, exp_accepts(m, c));
    chk({ph_tag, " ack count"}, n_ack, c);
    chk({ph_tag, " rd count"}, n_rd, exp_phase(m, c));
    chk({ph_tag, " wr count"}, n_wr, exp_phase(m, c));
    chk({ph_tag, " phase order"}, n_phase_bad, 0);
    chk("R7 remain at end", int'(remain), 0);
    chk("R7 done at end", int'(done), 1);
    chk("R2 accept to strobe", first_str - first_acc, LAT);
    if (m[0]) chk(m[1] ? "R9 back-to-back span" : "R3 back-to-back span",
                  last_str - first_str, exp_span(m, c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a7c3));
    repeat (3) @(negedge clk);
    chk("R1 accept in reset", int'(accept), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 strobes after reset", int'({ack, rd, wr}), 0);
    chk("R1 remain after reset", int'(remain), 0);
    chk("R1 done after reset", int'(done), 0);

    // directed mode patterns
    run_case(4'b1101, 4);   // edge burst dual, ack on write
    run_case(4'b0011, 5);   // level burst single
    run_case(4'b0100, 3);   // edge cycle-steal dual, ack on read
    run_case(4'b0000, 1);   // edge cycle-steal single, one transfer

    // R8: level release during the wait
    clear_mon(4'b0010);
    arm(4'b0010, 3);
    req_n = 1'b0;
    while (n_acc == 0) @(negedge clk);
    req_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R8 no transfer after release", n_ack, 0);
    chk("R8 no new accept while released", n_acc, 1);
    chk("R8 remain unchanged", int'(remain), 3);
    req_n = 1'b0;
    wait_done();
    @(negedge clk);
    chk("R8 resume accepts", n_acc, 4);
    chk("R8 resume transfers", n_ack, 3);

    // R10: request held after done
    repeat (10) @(negedge clk);
    chk("R10 no accept after done", n_acc, 4);
    chk("R10 done holds", int'(done), 1);
    req_n = 1'b1;

    // R10: zero count
    clear_mon(4'b0010);
    arm(4'b0010, 0);
    req_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 zero count done", int'(done), 1);
    chk("R10 zero count no accept", n_acc, 0);
    chk("R10 zero count no transfer", n_ack, 0);
    req_n = 1'b1;

    // random mode words and counts
    for (int k = 0; k < 24; k++) begin
      logic [3:0] m;
      int c;
      m = 4'($urandom);
      c = 1 + int'($urandom % 6);
      run_case(m, c);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule